// File: doc/BRIEF.md
# Line Loss-of-Signal Detector

This block watches the raw line data stream, one bit per clock, ahead of the zero-substitution decoder. It raises a loss-of-signal alarm as soon as the line has stayed at zero for a fixed run of samples. It drops the alarm only after the line has shown enough ones across a whole observation window.

Setting and clearing are deliberately asymmetric. A single long zero run sets the alarm at once. Recovery needs a minimum count of ones inside a fixed window, and that minimum depends on the line mode. The DS3 minimum is about one third of the window and the E3 minimum is about one quarter.

A one-cycle change pulse marks every transition of the alarm, so a status block can latch it. Decoding, clock recovery and analog signal detection are outside this block.

Top module: `line_sig_loss_mon`

## Requirements
- R1: While `rst_n` is low at a clock edge, `los_alarm` and `los_change` are 0 after that edge.
- R2: `los_alarm` goes to 1 at the clock edge that samples the 175th consecutive zero on `line_bit`. After 174 consecutive zeros it is still 0.
- R3: A sampled one on `line_bit` restarts the zero-run count. A run of 174 zeros, then a one, then 174 more zeros leaves `los_alarm` at 0.
- R4: The zero-run count saturates and does not wrap. An unbroken zero run of any length keeps `los_alarm` at 1 and produces no further `los_change` pulse.
- R5: While the alarm is 1, the samples are grouped into back-to-back windows of 175 clocks. The first window starts with the sample that follows the edge that set the alarm. The ones count is judged on the last sample of each window, and the alarm clears at that edge if the count meets the threshold.
- R6: With `mode_e3` = 0 (DS3), the threshold is 58 ones per window. A window with 58 ones clears the alarm, and a window with 57 ones or 44 ones does not.
- R7: With `mode_e3` = 1 (E3), the threshold is 44 ones per window. A window with 44 ones clears the alarm, and a window with 43 ones does not.
- R8: A window below the threshold restarts the check. Its ones do not carry into the next window, so two windows of 57 ones in DS3 mode leave the alarm set.
- R9: `los_change` is 1 for exactly the one cycle after an edge at which `los_alarm` changed value, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line-rate clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| line_bit | input | 1 | Raw line sample taken before zero-substitution decoding |
| mode_e3 | input | 1 | Clearing threshold select: 0 DS3, 1 E3 |
| los_alarm | output | 1 | Loss-of-signal alarm, active high |
| los_change | output | 1 | One-cycle pulse on each alarm transition |

## Verification
The embedded assertions check four rules on every cycle. The zero-run count stays within its saturation limit, and a one empties it on the next cycle. The window counter stays inside the window and rests at zero while there is no alarm. Every rise and every fall of the alarm, and every change pulse, has a legal cause on the previous edge. Whether the thresholds are exact can only be shown by the bench's scenarios, which place the window boundaries with directed 57/58 and 43/44 ones windows and random streams. The same scenarios show that the mode input is honoured and that a failed window starts counting afresh.

// File: rtl/lsl_pkg.sv
`timescale 1ns/1ps
// Package: shared defaults and the line-mode type for the loss-of-signal detector.
// Assumes the threshold values fit inside a window of LSL_WIN_LEN samples.
package lsl_pkg;
    localparam int LSL_RUN_LEN  = 175;  // zeros needed to declare loss
    localparam int LSL_WIN_LEN  = 175;  // samples per recovery window
    localparam int LSL_DS3_ONES = 58;   // about one third of the window
    localparam int LSL_E3_ONES  = 44;   // about one quarter of the window

    typedef enum logic {
        MODE_DS3 = 1'b0,
        MODE_E3  = 1'b1
    } line_mode_e;
endpackage

// File: rtl/lsl_zero_run.sv
`timescale 1ns/1ps
// Module: lsl_zero_run
// Counts consecutive zero samples on the raw line with a saturating counter.
// run_done is high while the sample at the coming edge completes or extends
// a run of RUN_LEN zeros.
// Assumes RUN_LEN >= 2.
module lsl_zero_run #(
    parameter int RUN_LEN = 175
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_bit,
    output logic run_done
);
    localparam int RUN_W = $clog2(RUN_LEN + 1);
    localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(RUN_LEN);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);

    logic [RUN_W-1:0] zrun_q;

    // Purpose: reset on a one, count zeros, hold at RUN_MAX.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zrun_q <= '0;
        end else if (line_bit) begin
            zrun_q <= '0;
        end else if (zrun_q != RUN_MAX) begin
            zrun_q <= zrun_q + 1'b1;
        end
    end

    // Purpose: flag that this zero completes (or extends) the loss run.
    always_comb begin
        run_done = !line_bit && (zrun_q >= RUN_LAST);
    end

    assert_run_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        zrun_q <= RUN_MAX);

    assert_one_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        line_bit |=> (zrun_q == '0));
endmodule

// File: rtl/lsl_density_win.sv
`timescale 1ns/1ps
// Module: lsl_density_win
// While active, splits the samples into back-to-back windows of WIN_LEN and
// counts the ones. On the last sample of a window it raises win_end, and it
// raises win_pass if the total meets the threshold of the current mode.
// Counters rest at zero while inactive and restart after every window.
// Assumes DS3_ONES and E3_ONES are at most WIN_LEN.
module lsl_density_win
    import lsl_pkg::*;
#(
    parameter int WIN_LEN  = 175,
    parameter int DS3_ONES = 58,
    parameter int E3_ONES  = 44
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       line_bit,
    input  line_mode_e mode,
    output logic       win_end,
    output logic       win_pass
);
    localparam int WCNT_W = $clog2(WIN_LEN);
    localparam int ONES_W = $clog2(WIN_LEN + 1);
    localparam logic [WCNT_W-1:0] WIN_LAST = WCNT_W'(WIN_LEN - 1);
    localparam logic [ONES_W:0]   THR_DS3  = (ONES_W + 1)'(DS3_ONES);
    localparam logic [ONES_W:0]   THR_E3   = (ONES_W + 1)'(E3_ONES);

    logic [WCNT_W-1:0] wcnt_q;
    logic [ONES_W-1:0] ones_q;
    logic [ONES_W:0]   total;
    logic [ONES_W:0]   thr;

    // Purpose: pick the threshold and judge the window on its last sample.
    always_comb begin
        thr      = (mode == MODE_E3) ? THR_E3 : THR_DS3;
        total    = {1'b0, ones_q} + {{ONES_W{1'b0}}, line_bit};
        win_end  = active && (wcnt_q == WIN_LAST);
        win_pass = win_end && (total >= thr);
    end

    // Purpose: advance the window position and the ones count.
    always_ff @(posedge clk) begin
        if (!rst_n || !active || win_end) begin
            wcnt_q <= '0;
            ones_q <= '0;
        end else begin
            wcnt_q <= wcnt_q + 1'b1;
            ones_q <= ones_q + {{(ONES_W-1){1'b0}}, line_bit};
        end
    end

    assert_win_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wcnt_q <= WIN_LAST);

    assert_idle_rest_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (wcnt_q == '0 && ones_q == '0));

    assert_fresh_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> (ones_q == '0));
endmodule

// File: rtl/lsl_alarm_ctl.sv
`timescale 1ns/1ps
// Module: lsl_alarm_ctl
// Holds the loss-of-signal alarm. A finished zero run sets it and takes
// priority. A passing window end clears it. A registered pulse marks each
// transition for status latching.
// Assumes win_end and win_pass are only high while the alarm is set.
module lsl_alarm_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic run_done,
    input  logic win_end,
    input  logic win_pass,
    output logic alarm,
    output logic change
);
    logic alarm_q, alarm_d, change_q;

    // Purpose: next alarm value, set before clear.
    always_comb begin
        if (run_done)
            alarm_d = 1'b1;
        else if (alarm_q && win_end && win_pass)
            alarm_d = 1'b0;
        else
            alarm_d = alarm_q;
    end

    // Purpose: register the alarm and its transition pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q  <= 1'b0;
            change_q <= 1'b0;
        end else begin
            alarm_q  <= alarm_d;
            change_q <= (alarm_d != alarm_q);
        end
    end

    assign alarm  = alarm_q;
    assign change = change_q;

    assert_rise_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_q) |-> $past(run_done));

    assert_fall_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alarm_q) |-> $past(win_end && win_pass));

    assert_change_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        change_q |-> (alarm_q != $past(alarm_q)));

    assert_change_missing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_q != $past(alarm_q)) |-> change_q);
endmodule

// File: rtl/line_sig_loss_mon.sv
`timescale 1ns/1ps
// Module: line_sig_loss_mon (top)
// Loss-of-signal monitor on the raw line stream. A long zero run sets the
// alarm. A window with enough ones, judged against the DS3 or E3 threshold,
// clears it.
// Assumes one line sample per clock and a synchronous active-low reset.
module line_sig_loss_mon
    import lsl_pkg::*;
#(
    parameter int RUN_LEN  = LSL_RUN_LEN,
    parameter int WIN_LEN  = LSL_WIN_LEN,
    parameter int DS3_ONES = LSL_DS3_ONES,
    parameter int E3_ONES  = LSL_E3_ONES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_bit,
    input  logic mode_e3,
    output logic los_alarm,
    output logic los_change
);
    line_mode_e mode_sel;
    logic       run_done;
    logic       win_end;
    logic       win_pass;
    logic       alarm;

    // Purpose: map the mode pin onto the mode type.
    always_comb begin
        mode_sel = mode_e3 ? MODE_E3 : MODE_DS3;
    end

    lsl_zero_run #(.RUN_LEN(RUN_LEN)) u_zero_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_bit (line_bit),
        .run_done (run_done)
    );

    lsl_density_win #(
        .WIN_LEN  (WIN_LEN),
        .DS3_ONES (DS3_ONES),
        .E3_ONES  (E3_ONES)
    ) u_density_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (alarm),
        .line_bit (line_bit),
        .mode     (mode_sel),
        .win_end  (win_end),
        .win_pass (win_pass)
    );

    lsl_alarm_ctl u_alarm_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_done (run_done),
        .win_end  (win_end),
        .win_pass (win_pass),
        .alarm    (alarm),
        .change   (los_change)
    );

    assign los_alarm = alarm;

    assert_no_window_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !alarm |-> !win_end);
endmodule

// File: tb/test_line_sig_loss_mon.sv
`timescale 1ns/1ps
// Bench for line_sig_loss_mon: directed corners plus seeded random streams,
// compared every cycle against a model built from the requirements.
module test_line_sig_loss_mon;
    localparam int RUN = 175;
    localparam int WIN = 175;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_bit = 1'b0;
    logic mode_e3 = 1'b0;
    logic los_alarm, los_change;

    int checks = 0;
    int errors = 0;

    // expected-value model state
    int m_zrun = 0, m_wcnt = 0, m_ones = 0;
    bit m_alarm = 0, m_change = 0;

    always #2.5 clk = ~clk;

    line_sig_loss_mon i_line_sig_loss_mon (
        .clk(clk), .rst_n(rst_n), .line_bit(line_bit), .mode_e3(mode_e3),
        .los_alarm(los_alarm), .los_change(los_change)
    );

    function automatic int thr_of(bit e3);
        return e3 ? 44 : 58;   // R6 / R7 thresholds
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // one model step for a sampled bit
    task automatic model_step(bit b, bit e3);
        bit done, last, pass, nxt;
        done = !b && (m_zrun >= RUN - 1);
        m_zrun = b ? 0 : ((m_zrun < RUN) ? m_zrun + 1 : RUN);
        last = m_alarm && (m_wcnt == WIN - 1);
        pass = last && ((m_ones + b) >= thr_of(e3));
        nxt = done ? 1'b1 : (pass ? 1'b0 : m_alarm);
        if (!m_alarm || last) begin m_wcnt = 0; m_ones = 0; end
        else begin m_wcnt++; m_ones += b; end
        m_change = (nxt != m_alarm);
        m_alarm = nxt;
    endtask

    task automatic step(bit b, bit e3, string tag);
        @(negedge clk);
        line_bit = b;
        mode_e3 = e3;
        @(posedge clk);
        #1;
        model_step(b, e3);
        check(tag, "los_alarm", los_alarm, m_alarm);
        check("R9", "los_change", los_change, m_change);
    endtask

    task automatic zeros(int n, bit e3, string tag);
        for (int i = 0; i < n; i++) step(1'b0, e3, tag);
    endtask

    // step zeros until the next sample opens a window
    task automatic align(bit e3);
        while (m_wcnt != 0) step(1'b0, e3, "R5");
    endtask

    // a whole window with n ones spread over it
    task automatic window(int n, bit e3, string tag);
        for (int i = 0; i < WIN; i++) step((i * n / WIN) != ((i + 1) * n / WIN), e3, tag);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5a17;
        void'($urandom(seed));
        // R1: reset state
        repeat (3) begin
            @(negedge clk); line_bit = $urandom_range(0, 1);
            @(posedge clk); #1;
            check("R1", "los_alarm in reset", los_alarm, 0);
            check("R1", "los_change in reset", los_change, 0);
        end
        @(negedge clk); rst_n = 1'b1; line_bit = 1'b1;
        @(posedge clk); #1; model_step(1'b1, 1'b0);

        // R3: a one breaks the run
        zeros(RUN - 1, 0, "R3");
        step(1'b1, 0, "R3");
        zeros(RUN - 1, 0, "R3");
        check("R3", "alarm after broken runs", los_alarm, 0);
        // R2: the 175th zero sets the alarm
        step(1'b0, 0, "R2");
        check("R2", "alarm at 175th zero", los_alarm, 1);
        check("R9", "change on set", los_change, 1);
        // R4: long run stays set, no pulse
        zeros(400, 0, "R4");
        check("R4", "alarm held on long run", los_alarm, 1);
        check("R4", "no pulse on long run", los_change, 0);

        // R6 / R8: DS3 threshold
        align(0);
        window(57, 0, "R6");
        check("R6", "DS3 57 ones keeps alarm", los_alarm, 1);
        window(57, 0, "R8");
        check("R8", "two 57 windows keep alarm", los_alarm, 1);
        window(44, 0, "R6");
        check("R6", "DS3 44 ones keeps alarm", los_alarm, 1);
        window(58, 0, "R6");
        check("R6", "DS3 58 ones clears", los_alarm, 0);
        check("R9", "change on clear", los_change, 1);

        // R7: E3 threshold
        step(1'b1, 1, "R7");
        zeros(RUN, 1, "R2");
        check("R2", "alarm set again", los_alarm, 1);
        align(1);
        window(43, 1, "R7");
        check("R7", "E3 43 ones keeps alarm", los_alarm, 1);
        window(44, 1, "R7");
        check("R7", "E3 44 ones clears", los_alarm, 0);

        // R5: random streams with bursts of silence and varying density
        for (int seg = 0; seg < 60; seg++) begin
            bit e3;
            int pct, len;
            e3 = $urandom_range(0, 1);
            if ($urandom_range(0, 2) == 0) begin
                zeros($urandom_range(150, 260), e3, "R5");
            end else begin
                pct = $urandom_range(15, 45);
                len = $urandom_range(100, 400);
                for (int i = 0; i < len; i++)
                    step($urandom_range(0, 99) < pct, e3, "R5");
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule